// File: doc/BRIEF.md
# Packet Stream Trailer Appender

This block sits on the transmit path of a packet pipeline. Its main input is a 256-bit beat stream with byte enables and first/last framing. It also takes a per-packet byte-length stream and a trailer stream, where the trailer is typically a CRC computed upstream. Each packet leaves the block with a fixed-size trailer written directly after its last valid payload byte. The block does not compute the trailer value.

The block takes the packet length together with the first beat. From that length it works out how many payload bytes occupy the final beat. The trailer is placed in the free lanes after those bytes. When the trailer does not fit, its leading bytes complete the final payload beat and one extra beat carries the remaining bytes. The last flag moves to whichever beat holds the final trailer byte. Two build-time switches reverse the byte order of the payload beats and of the trailer word, each on its own. All three inputs and the output use valid-ready handshakes. A beat moves only when valid and ready are both high.

Top module: `pkt_trailer_append`

## Requirements
- R1: One length word is consumed per packet, in the same cycle as that packet's first beat. No length is consumed on later beats.
- R2: One trailer word is consumed per packet, in the same cycle as the beat flagged last on the payload input.
- R3: A payload beat that is not flagged last is forwarded in the same cycle. Its data and enables are unchanged, and its last flag is low.
- R4: Let fill be ((length-1) mod 32)+1. On the final payload beat, lanes 0..fill-1 carry payload, and trailer byte i (bits 8i+7:8i of the trailer input) goes to lane fill+i while that lane is below 32. Unused lanes are zero.
- R5: When fill+T ≤ 32 (T = 4 by default), the final payload beat carries the last flag and its enables are set for lanes 0..fill+T-1.
- R6: When fill+T > 32, the final payload beat has all 32 enables set and its last flag low. The next output beat carries the remaining fill+T-32 trailer bytes from lane 0. It has those enables only, last high and first low, and no payload beat is accepted while it is pending.
- R7: With the payload swap option set, output lane k takes input lane 31-k. With the trailer swap option set, trailer byte i is taken from input byte T-1-i.
- R8: A first beat is neither accepted nor forwarded while no length is valid.
- R9: A beat flagged last is neither accepted nor forwarded while no trailer is valid.
- R10: While the output is not ready, no input is consumed and a pending output beat stays valid.
- R11: Back-to-back packets each use their own length for trailer placement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pkt_valid_i | input | 1 | Payload beat valid |
| pkt_ready_o | output | 1 | Payload beat accepted |
| pkt_data_i | input | 256 | Payload data, lane k at bits 8k+7:8k |
| pkt_be_i | input | 32 | Payload byte enables |
| pkt_first_i | input | 1 | First beat of a packet |
| pkt_last_i | input | 1 | Last payload beat of a packet |
| len_valid_i | input | 1 | Length word valid |
| len_ready_o | output | 1 | Length word consumed |
| len_i | input | 16 | Packet payload length in bytes (nonzero) |
| trl_valid_i | input | 1 | Trailer word valid |
| trl_ready_o | output | 1 | Trailer word consumed |
| trl_data_i | input | 32 | Trailer word, byte i at bits 8i+7:8i |
| out_valid_o | output | 1 | Output beat valid |
| out_ready_i | input | 1 | Output beat accepted downstream |
| out_data_o | output | 256 | Output data |
| out_be_o | output | 32 | Output byte enables |
| out_first_o | output | 1 | First output beat of a packet |
| out_last_o | output | 1 | Beat holding the final trailer byte |

## Verification
The assertions check the handshake rules on every cycle:
- a length is taken only alongside a first beat, and a trailer only alongside a last beat;
- nothing is consumed under backpressure;
- a first or last beat never moves without its side input;
- a spilled trailer is always followed immediately by a last-flagged extra beat that blocks the payload input.

Only the directed scenarios can show the lane-accurate result: where the trailer bytes land for a given length, the enable masks for fitted and split trailers, and the effect of the two swap options. These scenarios cover one-beat packets, exact fits, full final beats and back-to-back packets.

// File: rtl/pta_pkg.sv
package pta_pkg;
  typedef enum logic {
    ST_PAY   = 1'b0,
    ST_SPILL = 1'b1
  } pta_state_e;
endpackage

// File: rtl/pta_swap.sv
module pta_swap #(
  parameter int BYTES = 32,
  parameter bit EN    = 1'b0
) (
  input  logic [BYTES*8-1:0] in_i,
  output logic [BYTES*8-1:0] out_o
);
  if (EN) begin : g_rev
    for (genvar g = 0; g < BYTES; g++) begin : g_lane
      assign out_o[g*8 +: 8] = in_i[(BYTES-1-g)*8 +: 8];
    end
  end else begin : g_thru
    assign out_o = in_i;
  end
endmodule

// File: rtl/pta_merge.sv
// Builds the final payload beat with the trailer inserted after lane fill-1,
// plus the trailer bytes that spill into an extra beat.
module pta_merge #(
  parameter int BEAT_BYTES = 32,
  parameter int TRL_BYTES  = 4,
  localparam int FILL_W    = $clog2(BEAT_BYTES) + 1
) (
  input  logic [BEAT_BYTES*8-1:0] pay_i,
  input  logic [TRL_BYTES*8-1:0]  trl_i,
  input  logic [FILL_W-1:0]       fill_i,
  output logic [BEAT_BYTES*8-1:0] last_data_o,
  output logic [BEAT_BYTES-1:0]   last_be_o,
  output logic                    spill_o,
  output logic [TRL_BYTES*8-1:0]  spill_data_o,
  output logic [TRL_BYTES-1:0]    spill_be_o
);
  int f;

  always_comb begin
    f            = int'(fill_i);
    last_data_o  = '0;
    last_be_o    = '0;
    spill_data_o = '0;
    spill_be_o   = '0;
    for (int k = 0; k < BEAT_BYTES; k++) begin
      if (k < f) begin
        last_data_o[k*8 +: 8] = pay_i[k*8 +: 8];
        last_be_o[k]          = 1'b1;
      end else if (k - f < TRL_BYTES) begin
        last_data_o[k*8 +: 8] = trl_i[(k-f)*8 +: 8];
        last_be_o[k]          = 1'b1;
      end
    end
    for (int j = 0; j < TRL_BYTES; j++) begin
      if (BEAT_BYTES - f + j < TRL_BYTES) begin
        spill_data_o[j*8 +: 8] = trl_i[(BEAT_BYTES-f+j)*8 +: 8];
        spill_be_o[j]          = 1'b1;
      end
    end
  end

  assign spill_o = (int'(fill_i) + TRL_BYTES) > BEAT_BYTES;
endmodule

// File: rtl/pta_ctrl.sv
module pta_ctrl #(
  parameter int BEAT_BYTES = 32,
  localparam int FILL_W    = $clog2(BEAT_BYTES) + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pkt_valid_i,
  input  logic                 pkt_last_i,
  input  logic                 len_valid_i,
  input  logic [FILL_W-1:0]    len_fill_i,
  input  logic                 trl_valid_i,
  input  logic                 out_ready_i,
  input  logic                 spill_i,
  output pta_pkg::pta_state_e  state_o,
  output logic [FILL_W-1:0]    cur_fill_o,
  output logic                 pkt_ready_o,
  output logic                 len_ready_o,
  output logic                 trl_ready_o,
  output logic                 out_valid_o,
  output logic                 pay_go_o
);
  import pta_pkg::*;

  pta_state_e        state_q;
  logic              in_pkt_q;
  logic [FILL_W-1:0] fill_q;
  logic              side_ok;
  logic              gate;

  assign side_ok     = (in_pkt_q || len_valid_i) && (!pkt_last_i || trl_valid_i);
  assign gate        = (state_q == ST_PAY) && pkt_valid_i && side_ok;
  assign out_valid_o = (state_q == ST_SPILL) || gate;
  assign pay_go_o    = gate && out_ready_i;
  assign pkt_ready_o = (state_q == ST_PAY) && side_ok && out_ready_i;
  assign len_ready_o = pay_go_o && !in_pkt_q;
  assign trl_ready_o = pay_go_o && pkt_last_i;
  assign cur_fill_o  = in_pkt_q ? fill_q : len_fill_i;
  assign state_o     = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_PAY;
      in_pkt_q <= 1'b0;
      fill_q   <= '0;
    end else begin
      if (pay_go_o) begin
        if (!in_pkt_q) fill_q <= len_fill_i;
        in_pkt_q <= !pkt_last_i;
        if (pkt_last_i && spill_i) state_q <= ST_SPILL;
      end else if (state_q == ST_SPILL && out_ready_i) begin
        state_q <= ST_PAY;
      end
    end
  end

  // a second length is never drawn mid-packet
  p_len_once_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_pkt_q |-> !len_ready_o);

  p_first_needs_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_i && pkt_ready_o && !in_pkt_q |-> len_valid_i && len_ready_o);
endmodule

// File: rtl/pkt_trailer_append.sv
module pkt_trailer_append #(
  parameter int BEAT_BYTES = 32,
  parameter int TRL_BYTES  = 4,
  parameter int LEN_W      = 16,
  parameter bit SWAP_PKT   = 1'b0,
  parameter bit SWAP_TRL   = 1'b0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    pkt_valid_i,
  output logic                    pkt_ready_o,
  input  logic [BEAT_BYTES*8-1:0] pkt_data_i,
  input  logic [BEAT_BYTES-1:0]   pkt_be_i,
  input  logic                    pkt_first_i,
  input  logic                    pkt_last_i,
  input  logic                    len_valid_i,
  output logic                    len_ready_o,
  input  logic [LEN_W-1:0]        len_i,
  input  logic                    trl_valid_i,
  output logic                    trl_ready_o,
  input  logic [TRL_BYTES*8-1:0]  trl_data_i,
  output logic                    out_valid_o,
  input  logic                    out_ready_i,
  output logic [BEAT_BYTES*8-1:0] out_data_o,
  output logic [BEAT_BYTES-1:0]   out_be_o,
  output logic                    out_first_o,
  output logic                    out_last_o
);
  import pta_pkg::*;

  localparam int DATA_W = BEAT_BYTES * 8;
  localparam int OFF_W  = $clog2(BEAT_BYTES);
  localparam int FILL_W = OFF_W + 1;

  logic [DATA_W-1:0]      pay_sw;
  logic [TRL_BYTES*8-1:0] trl_sw;
  logic [OFF_W-1:0]       len_off;
  logic [FILL_W-1:0]      len_fill;
  logic [FILL_W-1:0]      cur_fill;
  pta_state_e             state;
  logic                   pay_go;
  logic [DATA_W-1:0]      last_data;
  logic [BEAT_BYTES-1:0]  last_be;
  logic                   spill;
  logic [TRL_BYTES*8-1:0] spill_data;
  logic [TRL_BYTES-1:0]   spill_be;
  logic [TRL_BYTES*8-1:0] spill_data_q;
  logic [TRL_BYTES-1:0]   spill_be_q;

  // payload bytes held in the final beat: ((len-1) mod BEAT)+1
  assign len_off  = len_i[OFF_W-1:0] - OFF_W'(1);
  assign len_fill = FILL_W'(len_off) + FILL_W'(1);

  pta_swap #(.BYTES(BEAT_BYTES), .EN(SWAP_PKT)) u_swap_pkt (
    .in_i (pkt_data_i),
    .out_o(pay_sw)
  );

  pta_swap #(.BYTES(TRL_BYTES), .EN(SWAP_TRL)) u_swap_trl (
    .in_i (trl_data_i),
    .out_o(trl_sw)
  );

  pta_merge #(.BEAT_BYTES(BEAT_BYTES), .TRL_BYTES(TRL_BYTES)) u_merge (
    .pay_i       (pay_sw),
    .trl_i       (trl_sw),
    .fill_i      (cur_fill),
    .last_data_o (last_data),
    .last_be_o   (last_be),
    .spill_o     (spill),
    .spill_data_o(spill_data),
    .spill_be_o  (spill_be)
  );

  pta_ctrl #(.BEAT_BYTES(BEAT_BYTES)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pkt_valid_i(pkt_valid_i),
    .pkt_last_i (pkt_last_i),
    .len_valid_i(len_valid_i),
    .len_fill_i (len_fill),
    .trl_valid_i(trl_valid_i),
    .out_ready_i(out_ready_i),
    .spill_i    (spill),
    .state_o    (state),
    .cur_fill_o (cur_fill),
    .pkt_ready_o(pkt_ready_o),
    .len_ready_o(len_ready_o),
    .trl_ready_o(trl_ready_o),
    .out_valid_o(out_valid_o),
    .pay_go_o   (pay_go)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spill_data_q <= '0;
      spill_be_q   <= '0;
    end else if (pay_go && pkt_last_i && spill) begin
      spill_data_q <= spill_data;
      spill_be_q   <= spill_be;
    end
  end

  always_comb begin
    if (state == ST_SPILL) begin
      out_data_o  = DATA_W'(spill_data_q);
      out_be_o    = BEAT_BYTES'(spill_be_q);
      out_first_o = 1'b0;
      out_last_o  = 1'b1;
    end else if (pkt_last_i) begin
      out_data_o  = last_data;
      out_be_o    = last_be;
      out_first_o = pkt_first_i;
      out_last_o  = !spill;
    end else begin
      out_data_o  = pay_sw;
      out_be_o    = pkt_be_i;
      out_first_o = pkt_first_i;
      out_last_o  = 1'b0;
    end
  end

  p_len_nonzero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_valid_i |-> len_i != '0);

  p_trl_on_last_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trl_valid_i && trl_ready_o |-> pkt_valid_i && pkt_ready_o && pkt_last_i);

  p_spill_follows_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(trl_valid_i && trl_ready_o && !out_last_o)
      |-> out_valid_o && out_last_o && !out_first_o && !pkt_ready_o);

  p_last_needs_trl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_i && pkt_ready_o && pkt_last_i |-> trl_valid_i);

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_ready_i |-> !pkt_ready_o && !trl_ready_o && !len_ready_o);
endmodule

// File: tb/pkt_trailer_append_test.sv
module pkt_trailer_append_test;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         pkt_valid = 1'b0, pkt_first = 1'b0, pkt_last = 1'b0;
  logic [255:0] pkt_data = '0;
  logic [31:0]  pkt_be = '0;
  logic         len_valid = 1'b0;
  logic [15:0]  len = '0;
  logic         trl_valid = 1'b0;
  logic [31:0]  trl = '0;
  logic         out_ready = 1'b0;

  logic         pkt_ready, len_ready, trl_ready;
  logic         o_valid, o_first, o_last;
  logic [255:0] o_data;
  logic [31:0]  o_be;
  logic         s_pkt_ready, s_len_ready, s_trl_ready;
  logic         s_valid, s_first, s_last;
  logic [255:0] s_data;
  logic [31:0]  s_be;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  pkt_trailer_append uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .pkt_valid_i(pkt_valid), .pkt_ready_o(pkt_ready), .pkt_data_i(pkt_data),
    .pkt_be_i(pkt_be), .pkt_first_i(pkt_first), .pkt_last_i(pkt_last),
    .len_valid_i(len_valid), .len_ready_o(len_ready), .len_i(len),
    .trl_valid_i(trl_valid), .trl_ready_o(trl_ready), .trl_data_i(trl),
    .out_valid_o(o_valid), .out_ready_i(out_ready), .out_data_o(o_data),
    .out_be_o(o_be), .out_first_o(o_first), .out_last_o(o_last)
  );

  pkt_trailer_append #(.SWAP_PKT(1'b1), .SWAP_TRL(1'b1)) uut_sw (
    .clk_i(clk), .rst_ni(rst_ni),
    .pkt_valid_i(pkt_valid), .pkt_ready_o(s_pkt_ready), .pkt_data_i(pkt_data),
    .pkt_be_i(pkt_be), .pkt_first_i(pkt_first), .pkt_last_i(pkt_last),
    .len_valid_i(len_valid), .len_ready_o(s_len_ready), .len_i(len),
    .trl_valid_i(trl_valid), .trl_ready_o(s_trl_ready), .trl_data_i(trl),
    .out_valid_o(s_valid), .out_ready_i(out_ready), .out_data_o(s_data),
    .out_be_o(s_be), .out_first_o(s_first), .out_last_o(s_last)
  );

  task automatic chk(input string rq, input string what, input logic [255:0] act,
                     input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] lo_mask(input int n);
    logic [31:0] m = '0;
    for (int i = 0; i < 32; i++) m[i] = (i < n);
    return m;
  endfunction

  function automatic logic [7:0] pbyte(input logic [7:0] seed, input int b, input int k);
    return 8'(int'(seed) + b * 32 + k);
  endfunction

  function automatic logic [7:0] tbyte(input logic [31:0] t, input int i, input bit sw);
    return sw ? t[(3-i)*8 +: 8] : t[i*8 +: 8];
  endfunction

  function automatic logic [255:0] in_beat(input logic [7:0] seed, input int b);
    logic [255:0] d;
    for (int k = 0; k < 32; k++) d[k*8 +: 8] = pbyte(seed, b, k);
    return d;
  endfunction

  function automatic logic [255:0] exp_beat(input logic [7:0] seed, input int b,
      input bit is_last, input int fill, input logic [31:0] t, input bit sw);
    logic [255:0] d = '0;
    for (int k = 0; k < 32; k++) begin
      if (!is_last || k < fill) d[k*8 +: 8] = pbyte(seed, b, sw ? 31 - k : k);
      else if (k - fill < 4)   d[k*8 +: 8] = tbyte(t, k - fill, sw);
    end
    return d;
  endfunction

  function automatic logic [255:0] exp_spill(input int fill, input logic [31:0] t,
                                             input bit sw);
    logic [255:0] d = '0;
    for (int j = 0; j < 4; j++)
      if (32 - fill + j < 4) d[j*8 +: 8] = tbyte(t, 32 - fill + j, sw);
    return d;
  endfunction

  // One packet; stall: R10 backpressure on last beat; hold_trl: R9 trailer late.
  task automatic run_pkt(input string sc, input int plen, input logic [31:0] t,
                         input logic [7:0] seed, input bit stall, input bit hold_trl);
    int nb = (plen + 31) / 32;
    int fill = plen - (nb - 1) * 32;
    bit spl = (fill + 4) > 32;
    for (int b = 0; b < nb; b++) begin
      bit lst = (b == nb - 1);
      @(negedge clk);
      if (b == 0) begin len_valid = 1'b1; len = 16'(plen); end
      else len_valid = 1'b0;
      pkt_valid = 1'b1; pkt_first = (b == 0); pkt_last = lst;
      pkt_data = in_beat(seed, b);
      pkt_be = lst ? lo_mask(fill) : 32'hFFFF_FFFF;
      trl = t; trl_valid = lst && !hold_trl; out_ready = 1'b1;
      if (lst && hold_trl) begin
        #1;
        chk({sc, " R9"}, "pkt_ready without trailer", 256'(pkt_ready), 256'(0));
        chk({sc, " R9"}, "out_valid without trailer", 256'(o_valid), 256'(0));
        @(negedge clk); trl_valid = 1'b1;
      end
      if (lst && stall) begin
        out_ready = 1'b0; #1;
        chk({sc, " R10"}, "readies under stall",
            256'({pkt_ready, len_ready, trl_ready}), 256'(0));
        chk({sc, " R10"}, "out_valid under stall", 256'(o_valid), 256'(1));
        @(negedge clk); out_ready = 1'b1;
      end
      #1;
      chk({sc, " R1"}, "len_ready", 256'(len_ready), 256'(b == 0));
      chk({sc, " R2"}, "trl_ready", 256'(trl_ready), 256'(lst));
      chk({sc, " R3"}, "valid/ready", 256'({o_valid, pkt_ready}), 256'(3));
      chk({sc, " R4"}, "data", o_data, exp_beat(seed, b, lst, fill, t, 1'b0));
      chk({sc, " R7"}, "swapped data", s_data, exp_beat(seed, b, lst, fill, t, 1'b1));
      chk({sc, " R5"}, "be",
          256'(o_be), 256'(lst ? lo_mask(spl ? 32 : fill + 4) : 32'hFFFF_FFFF));
      chk({sc, " R5"}, "first/last",
          256'({o_first, o_last}), 256'({b == 0, lst && !spl}));
      chk({sc, " R7"}, "swapped be/last",
          256'({s_be, s_last}), 256'({o_be, o_last}));
      @(posedge clk);
    end
    @(negedge clk);
    pkt_valid = 1'b0; trl_valid = 1'b0; len_valid = 1'b0;
    pkt_first = 1'b0; pkt_last = 1'b0;
    #1;
    if (spl) begin
      chk({sc, " R6"}, "spill valid/first/last/pkt_ready",
          256'({o_valid, o_first, o_last, pkt_ready}), 256'(4'b1010));
      chk({sc, " R6"}, "spill be", 256'(o_be), 256'(lo_mask(fill + 4 - 32)));
      chk({sc, " R6"}, "spill data", o_data, exp_spill(fill, t, 1'b0));
      chk({sc, " R7"}, "swapped spill data", s_data, exp_spill(fill, t, 1'b1));
      @(posedge clk);
      @(negedge clk);
      #1;
    end
    chk({sc, " R6"}, "idle after packet", 256'(o_valid), 256'(0));
  endtask

  task automatic t_wait_len();
    @(negedge clk);
    pkt_valid = 1'b1; pkt_first = 1'b1; pkt_last = 1'b0; len_valid = 1'b0;
    out_ready = 1'b1; pkt_data = in_beat(8'h11, 0); pkt_be = '1;
    #1;
    chk("R8", "pkt_ready without length", 256'(pkt_ready), 256'(0));
    chk("R8", "out_valid without length", 256'(o_valid), 256'(0));
    @(negedge clk);
    pkt_valid = 1'b0; pkt_first = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk("R8", "reset out_valid", 256'(o_valid), 256'(0));
    chk("R8", "reset pkt_ready", 256'(pkt_ready), 256'(0));
    t_wait_len();
    run_pkt("one-beat fit",      10, 32'hA1B2C3D4, 8'h00, 1'b0, 1'b0);
    run_pkt("multi-beat fit",    70, 32'h01020304, 8'h40, 1'b0, 1'b0);
    run_pkt("exact fit",         28, 32'hDEADBEEF, 8'h80, 1'b0, 1'b0);
    run_pkt("split two bytes",   30, 32'h55667788, 8'h20, 1'b0, 1'b0);
    run_pkt("full final beat",   64, 32'hCAFEF00D, 8'h33, 1'b0, 1'b0);
    run_pkt("one byte",           1, 32'h99AABBCC, 8'h77, 1'b0, 1'b0);
    run_pkt("stall last",        45, 32'h13572468, 8'h05, 1'b1, 1'b0);
    run_pkt("late trailer",      95, 32'hFEEDFACE, 8'h90, 1'b0, 1'b1);
    run_pkt("R11 back-to-back a", 33, 32'h0BADCAFE, 8'h0F, 1'b0, 1'b0);
    run_pkt("R11 back-to-back b", 31, 32'h12345678, 8'hF0, 1'b1, 1'b0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule